// File: doc/BRIEF.md
# Memory Request Slot Tracker

This block manages a small pool of request slots for a load/store unit shared by several hardware threads. Each memory instruction that enters the unit claims a slot. The slot holds a valid bit, the owning thread number, the instruction's sequence number and three status flags: waiting on translation-fault service, cache access outstanding, and killed by a squash. The cache and the translation unit are not part of this block. Their effects reach it as single-cycle event pulses, each naming a slot: a fault, an issue, a fault-service event, a completion and a release.

A translation fault on a slot stalls that slot and blocks its thread. The faulting sequence number is recorded, and new allocations from the blocked thread are refused until the block is lifted. A squash command names a thread and a sequence number. It kills the younger requests of that thread. Idle slots are freed at once. A slot still waiting on the cache or on fault service is kept until that event arrives, and then it is freed. A squash raised by a memory stall keeps the stalling instruction alive.

Top module: `mrt_slot_tracker`

## Requirements
- R1: After reset every slot is free with all status flags clear, and no thread is blocked.
- R2: An allocation request is granted combinationally to the lowest-index free slot. From the next cycle that slot is valid and holds the request's thread number and sequence number, with its status flags clear.
- R3: When every slot is valid and no squash frees one in the same cycle, an allocation request is refused (grant low).
- R4: An allocation request from a blocked thread is refused. A request from an unblocked thread is still granted in the same state.
- R5: A fault pulse on a valid, live slot sets that slot's translation-stall flag and blocks the owning thread from the next cycle.
- R6: A squash for thread T with threshold S marks as squashed only the valid, not yet squashed slots of thread T whose sequence number is strictly greater than S, compared as unsigned. A marked slot with no pending access and no translation stall is freed in the same update. Slots of other threads, and slots with sequence numbers equal to or below S, are unchanged.
- R7: A squashed slot with a pending access stays valid and is skipped by later squashes. Its completion pulse clears the pending flag and frees it, and delivery stays low.
- R8: Squashing a translation-stalled slot lifts its thread's block at once, as does a squash whose threshold is below the recorded faulting sequence number. The slot stays valid until its fault-service pulse, which frees it. A fault-service pulse on any stalled slot clears the stall and lifts the owning thread's block.
- R9: When the memory-stall flag accompanies a squash, the threshold is the given sequence number plus one. The instruction carrying that number survives.
- R10: A squash and an allocation in the same cycle act in that order. Slots freed by the squash, and a block it lifts, are visible to the allocation. The newly allocated slot is not squashed.
- R11: An issue pulse on a live slot sets its pending flag. A completion pulse on a live pending slot raises delivery in that cycle and clears the pending flag. A release pulse frees a live slot only when it is neither pending nor stalled, and is ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request |
| alloc_tid_i | input | TID_W | Requesting thread |
| alloc_seq_i | input | SEQ_W | Sequence number of the requesting instruction |
| alloc_gnt_o | output | 1 | Allocation granted this cycle |
| alloc_slot_o | output | SLOT_W | Slot granted |
| fault_i | input | 1 | Translation fault on a slot |
| fault_slot_i | input | SLOT_W | Faulting slot |
| issue_i | input | 1 | Access sent to the cache |
| issue_slot_i | input | SLOT_W | Issuing slot |
| fault_svc_i | input | 1 | Fault-service event fired |
| fault_svc_slot_i | input | SLOT_W | Serviced slot |
| cmpl_i | input | 1 | Cache completion |
| cmpl_slot_i | input | SLOT_W | Completing slot |
| deliver_o | output | 1 | Completion data goes to a live instruction |
| release_i | input | 1 | Normal release of a finished slot |
| release_slot_i | input | SLOT_W | Released slot |
| squash_i | input | 1 | Squash command |
| squash_tid_i | input | TID_W | Thread to squash |
| squash_seq_i | input | SEQ_W | Squash sequence number |
| squash_mem_stall_i | input | 1 | Squash raised by a memory stall |
| slot_valid_o | output | NUM_SLOTS | Slot occupied |
| slot_tlb_stall_o | output | NUM_SLOTS | Slot awaiting fault service |
| slot_pending_o | output | NUM_SLOTS | Slot has an access outstanding |
| slot_squashed_o | output | NUM_SLOTS | Slot killed, awaiting its event |
| slot_tid_o | output | NUM_SLOTS*TID_W | Thread of each slot, slot 0 in the low bits |
| slot_seq_o | output | NUM_SLOTS*SEQ_W | Sequence number of each slot, slot 0 in the low bits |
| thread_blocked_o | output | NUM_THREADS | Thread refused allocation |

## Verification
The hardest states to reach are the ones where a squash meets a slot that cannot be freed yet. A squashed slot with an access in flight has to be built by allocating and issuing it before a squash with a lower threshold arrives. The bench then sends a second squash to show the slot is skipped, and tries a release while it is pending. A squashed, translation-stalled slot is built by faulting a slot and squashing its thread, which also lifts the block. For the squash-before-allocation ordering, the bench fills the pool, or blocks a thread, and drives the squash and the allocation in the same cycle. The grant is then sampled before the edge.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef struct packed {
    logic valid;
    logic tlb_stall;
    logic pending;
    logic squashed;
  } slot_flags_t;
endpackage

// File: rtl/mrt_squash_eval.sv
module mrt_squash_eval #(
  parameter int NUM_SLOTS = 4,
  parameter int TID_W     = 1,
  parameter int SEQ_W     = 16
) (
  input  logic                                  en_i,
  input  logic [TID_W-1:0]                      tid_i,
  input  logic [SEQ_W:0]                        thr_i,
  input  mrt_pkg::slot_flags_t [NUM_SLOTS-1:0]  flags_i,
  input  logic [NUM_SLOTS-1:0][TID_W-1:0]       slot_tid_i,
  input  logic [NUM_SLOTS-1:0][SEQ_W-1:0]       slot_seq_i,
  output logic [NUM_SLOTS-1:0]                  hit_o,
  output logic [NUM_SLOTS-1:0]                  free_o,
  output logic                                  stall_hit_o
);
  logic [NUM_SLOTS-1:0] stall_vec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign hit_o[i] = en_i && flags_i[i].valid && !flags_i[i].squashed &&
                      (slot_tid_i[i] == tid_i) && ({1'b0, slot_seq_i[i]} > thr_i);
    assign free_o[i]    = hit_o[i] && !flags_i[i].pending && !flags_i[i].tlb_stall;
    assign stall_vec[i] = hit_o[i] && flags_i[i].tlb_stall;
  end

  assign stall_hit_o = |stall_vec;
endmodule

// File: rtl/mrt_alloc_pick.sv
module mrt_alloc_pick #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic [NUM_SLOTS-1:0] free_i,
  output logic                 any_o,
  output logic [SLOT_W-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = SLOT_W'(i);
    end
  end

  assign any_o = |free_i;
endmodule

// File: rtl/mrt_thread_block.sv
module mrt_thread_block #(
  parameter int NUM_THREADS = 2,
  parameter int TID_W       = 1,
  parameter int SEQ_W       = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_en_i,
  input  logic [TID_W-1:0]       set_tid_i,
  input  logic [SEQ_W-1:0]       set_seq_i,
  input  logic                   sq_en_i,
  input  logic [TID_W-1:0]       sq_tid_i,
  input  logic [SEQ_W:0]         sq_thr_i,
  input  logic                   sq_stall_hit_i,
  input  logic                   svc_en_i,
  input  logic [TID_W-1:0]       svc_tid_i,
  output logic [NUM_THREADS-1:0] blk_o,
  output logic [NUM_THREADS-1:0] blk_eff_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic             blk_q;
    logic [SEQ_W-1:0] bseq_q;
    logic             sq_clr, svc_clr, set_hit;

    assign sq_clr  = sq_en_i && (sq_tid_i == TID_W'(t)) && blk_q &&
                     (({1'b0, bseq_q} > sq_thr_i) || sq_stall_hit_i);
    assign svc_clr = svc_en_i && (svc_tid_i == TID_W'(t));
    assign set_hit = set_en_i && (set_tid_i == TID_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blk_q  <= 1'b0;
        bseq_q <= '0;
      end else if (set_hit) begin
        blk_q  <= 1'b1;
        bseq_q <= set_seq_i;
      end else if (sq_clr || svc_clr) begin
        blk_q  <= 1'b0;
      end
    end

    assign blk_o[t]     = blk_q;
    // squash lands before allocation in the same cycle
    assign blk_eff_o[t] = blk_q && !sq_clr;
  end
endmodule

// File: rtl/mrt_slot_tracker.sv
module mrt_slot_tracker #(
  parameter int NUM_SLOTS   = 4,
  parameter int NUM_THREADS = 2,
  parameter int SEQ_W       = 16,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_req_i,
  input  logic [TID_W-1:0]             alloc_tid_i,
  input  logic [SEQ_W-1:0]             alloc_seq_i,
  output logic                         alloc_gnt_o,
  output logic [SLOT_W-1:0]            alloc_slot_o,
  input  logic                         fault_i,
  input  logic [SLOT_W-1:0]            fault_slot_i,
  input  logic                         issue_i,
  input  logic [SLOT_W-1:0]            issue_slot_i,
  input  logic                         fault_svc_i,
  input  logic [SLOT_W-1:0]            fault_svc_slot_i,
  input  logic                         cmpl_i,
  input  logic [SLOT_W-1:0]            cmpl_slot_i,
  output logic                         deliver_o,
  input  logic                         release_i,
  input  logic [SLOT_W-1:0]            release_slot_i,
  input  logic                         squash_i,
  input  logic [TID_W-1:0]             squash_tid_i,
  input  logic [SEQ_W-1:0]             squash_seq_i,
  input  logic                         squash_mem_stall_i,
  output logic [NUM_SLOTS-1:0]         slot_valid_o,
  output logic [NUM_SLOTS-1:0]         slot_tlb_stall_o,
  output logic [NUM_SLOTS-1:0]         slot_pending_o,
  output logic [NUM_SLOTS-1:0]         slot_squashed_o,
  output logic [NUM_SLOTS*TID_W-1:0]   slot_tid_o,
  output logic [NUM_SLOTS*SEQ_W-1:0]   slot_seq_o,
  output logic [NUM_THREADS-1:0]       thread_blocked_o
);
  import mrt_pkg::*;

  slot_flags_t [NUM_SLOTS-1:0]       flg_q, flg_d;
  logic [NUM_SLOTS-1:0][TID_W-1:0]   tid_q, tid_d;
  logic [NUM_SLOTS-1:0][SEQ_W-1:0]   seq_q, seq_d;

  logic [SEQ_W:0]        sq_thr;
  logic [NUM_SLOTS-1:0]  sq_hit, sq_free, free_vec, valid_vec;
  logic                  sq_stall_hit, any_free;
  logic [SLOT_W-1:0]     pick_idx;
  logic [NUM_THREADS-1:0] blk, blk_eff;
  logic                  set_en, svc_en;

  // memory-stall squash spares the stalling instruction
  assign sq_thr = {1'b0, squash_seq_i} + {{SEQ_W{1'b0}}, squash_mem_stall_i};

  mrt_squash_eval #(
    .NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W), .SEQ_W(SEQ_W)
  ) u_sq (
    .en_i        (squash_i),
    .tid_i       (squash_tid_i),
    .thr_i       (sq_thr),
    .flags_i     (flg_q),
    .slot_tid_i  (tid_q),
    .slot_seq_i  (seq_q),
    .hit_o       (sq_hit),
    .free_o      (sq_free),
    .stall_hit_o (sq_stall_hit)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_vld
    assign valid_vec[i] = flg_q[i].valid;
  end
  assign free_vec = ~valid_vec | sq_free;

  mrt_alloc_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .free_i (free_vec),
    .any_o  (any_free),
    .idx_o  (pick_idx)
  );

  assign set_en = fault_i && flg_q[fault_slot_i].valid && !flg_q[fault_slot_i].squashed;
  assign svc_en = fault_svc_i && flg_q[fault_svc_slot_i].tlb_stall;

  mrt_thread_block #(
    .NUM_THREADS(NUM_THREADS), .TID_W(TID_W), .SEQ_W(SEQ_W)
  ) u_blk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .set_en_i       (set_en),
    .set_tid_i      (tid_q[fault_slot_i]),
    .set_seq_i      (seq_q[fault_slot_i]),
    .sq_en_i        (squash_i),
    .sq_tid_i       (squash_tid_i),
    .sq_thr_i       (sq_thr),
    .sq_stall_hit_i (sq_stall_hit),
    .svc_en_i       (svc_en),
    .svc_tid_i      (tid_q[fault_svc_slot_i]),
    .blk_o          (blk),
    .blk_eff_o      (blk_eff)
  );

  assign alloc_gnt_o  = alloc_req_i && any_free && !blk_eff[alloc_tid_i];
  assign alloc_slot_o = pick_idx;
  assign deliver_o    = cmpl_i && flg_q[cmpl_slot_i].pending && !flg_q[cmpl_slot_i].squashed;

  // order: squash, slot events, allocation
  always_comb begin
    flg_d = flg_q;
    tid_d = tid_q;
    seq_d = seq_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sq_hit[i]) begin
        flg_d[i].squashed = 1'b1;
        if (sq_free[i]) flg_d[i] = '0;
      end
    end
    if (fault_i && flg_d[fault_slot_i].valid && !flg_d[fault_slot_i].squashed)
      flg_d[fault_slot_i].tlb_stall = 1'b1;
    if (issue_i && flg_d[issue_slot_i].valid && !flg_d[issue_slot_i].squashed &&
        !flg_d[issue_slot_i].tlb_stall)
      flg_d[issue_slot_i].pending = 1'b1;
    if (fault_svc_i && flg_d[fault_svc_slot_i].tlb_stall) begin
      flg_d[fault_svc_slot_i].tlb_stall = 1'b0;
      if (flg_d[fault_svc_slot_i].squashed) flg_d[fault_svc_slot_i] = '0;
    end
    if (cmpl_i && flg_d[cmpl_slot_i].pending) begin
      flg_d[cmpl_slot_i].pending = 1'b0;
      if (flg_d[cmpl_slot_i].squashed) flg_d[cmpl_slot_i] = '0;
    end
    if (release_i && flg_d[release_slot_i].valid && !flg_d[release_slot_i].pending &&
        !flg_d[release_slot_i].tlb_stall && !flg_d[release_slot_i].squashed)
      flg_d[release_slot_i] = '0;
    if (alloc_gnt_o) begin
      flg_d[pick_idx]       = '0;
      flg_d[pick_idx].valid = 1'b1;
      tid_d[pick_idx]       = alloc_tid_i;
      seq_d[pick_idx]       = alloc_seq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q <= '0;
      tid_q <= '0;
      seq_q <= '0;
    end else begin
      flg_q <= flg_d;
      tid_q <= tid_d;
      seq_q <= seq_d;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_out
    assign slot_valid_o[i]     = flg_q[i].valid;
    assign slot_tlb_stall_o[i] = flg_q[i].tlb_stall;
    assign slot_pending_o[i]   = flg_q[i].pending;
    assign slot_squashed_o[i]  = flg_q[i].squashed;
    assign slot_tid_o[i*TID_W +: TID_W] = tid_q[i];
    assign slot_seq_o[i*SEQ_W +: SEQ_W] = seq_q[i];
  end

  assign thread_blocked_o = blk;
endmodule

// File: rtl/mrt_slot_tracker_chk.sv
module mrt_slot_tracker_chk #(
  parameter int NUM_SLOTS   = 4,
  parameter int NUM_THREADS = 2,
  parameter int SLOT_W      = 2,
  parameter int TID_W       = 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   alloc_gnt_o,
  input logic [SLOT_W-1:0]      alloc_slot_o,
  input logic [TID_W-1:0]       alloc_tid_i,
  input logic                   squash_i,
  input logic                   fault_i,
  input logic [SLOT_W-1:0]      fault_slot_i,
  input logic                   fault_svc_i,
  input logic                   cmpl_i,
  input logic [SLOT_W-1:0]      cmpl_slot_i,
  input logic                   deliver_o,
  input logic                   release_i,
  input logic [SLOT_W-1:0]      release_slot_i,
  input logic [NUM_SLOTS-1:0]   slot_valid_o,
  input logic [NUM_SLOTS-1:0]   slot_tlb_stall_o,
  input logic [NUM_SLOTS-1:0]   slot_pending_o,
  input logic [NUM_SLOTS-1:0]   slot_squashed_o,
  input logic [NUM_THREADS-1:0] thread_blocked_o
);
  // R2
  gnt_fills_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_gnt_o |=> slot_valid_o[$past(alloc_slot_o)]);

  // R3
  full_refuses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&slot_valid_o) && !squash_i) |-> !alloc_gnt_o);

  // R4
  blocked_refuses_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_gnt_o && !squash_i) |-> !thread_blocked_o[alloc_tid_i]);

  // R5
  fault_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && !squash_i && !fault_svc_i && slot_valid_o[fault_slot_i] &&
     !slot_squashed_o[fault_slot_i]) |=> slot_tlb_stall_o[$past(fault_slot_i)]);

  // R7
  no_deliver_squashed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> (slot_pending_o[cmpl_slot_i] && !slot_squashed_o[cmpl_slot_i]));

  // R11
  release_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && slot_pending_o[release_slot_i] &&
     !(cmpl_i && cmpl_slot_i == release_slot_i)) |=> slot_valid_o[$past(release_slot_i)]);
endmodule

bind mrt_slot_tracker mrt_slot_tracker_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_THREADS(NUM_THREADS), .SLOT_W(SLOT_W), .TID_W(TID_W)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .alloc_gnt_o      (alloc_gnt_o),
  .alloc_slot_o     (alloc_slot_o),
  .alloc_tid_i      (alloc_tid_i),
  .squash_i         (squash_i),
  .fault_i          (fault_i),
  .fault_slot_i     (fault_slot_i),
  .fault_svc_i      (fault_svc_i),
  .cmpl_i           (cmpl_i),
  .cmpl_slot_i      (cmpl_slot_i),
  .deliver_o        (deliver_o),
  .release_i        (release_i),
  .release_slot_i   (release_slot_i),
  .slot_valid_o     (slot_valid_o),
  .slot_tlb_stall_o (slot_tlb_stall_o),
  .slot_pending_o   (slot_pending_o),
  .slot_squashed_o  (slot_squashed_o),
  .thread_blocked_o (thread_blocked_o)
);

// File: tb/tb_mrt_slot_tracker.sv
module tb_mrt_slot_tracker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_req_i, alloc_tid_i;
  logic [15:0] alloc_seq_i;
  logic        alloc_gnt_o;
  logic [1:0]  alloc_slot_o;
  logic        fault_i, issue_i, fault_svc_i, cmpl_i, release_i;
  logic [1:0]  fault_slot_i, issue_slot_i, fault_svc_slot_i, cmpl_slot_i, release_slot_i;
  logic        deliver_o;
  logic        squash_i, squash_tid_i, squash_mem_stall_i;
  logic [15:0] squash_seq_i;
  logic [3:0]  slot_valid_o, slot_tlb_stall_o, slot_pending_o, slot_squashed_o;
  logic [3:0]  slot_tid_o;
  logic [63:0] slot_seq_o;
  logic [1:0]  thread_blocked_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk_i = ~clk_i;

  mrt_slot_tracker dut (
    .clk_i, .rst_ni, .alloc_req_i, .alloc_tid_i, .alloc_seq_i, .alloc_gnt_o, .alloc_slot_o,
    .fault_i, .fault_slot_i, .issue_i, .issue_slot_i, .fault_svc_i, .fault_svc_slot_i,
    .cmpl_i, .cmpl_slot_i, .deliver_o, .release_i, .release_slot_i,
    .squash_i, .squash_tid_i, .squash_seq_i, .squash_mem_stall_i,
    .slot_valid_o, .slot_tlb_stall_o, .slot_pending_o, .slot_squashed_o,
    .slot_tid_o, .slot_seq_o, .thread_blocked_o
  );

  typedef struct packed {
    logic        tid;
    logic [15:0] seq;
    logic        gnt;
    logic [1:0]  slot;
  } vec_t;

  // R2/R3: fill from empty, then one too many
  localparam vec_t VEC [5] = '{
    '{1'b0, 16'd10, 1'b1, 2'd0},
    '{1'b1, 16'd20, 1'b1, 2'd1},
    '{1'b0, 16'd30, 1'b1, 2'd2},
    '{1'b1, 16'd40, 1'b1, 2'd3},
    '{1'b0, 16'd50, 1'b0, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req_i = 0; alloc_tid_i = 0; alloc_seq_i = 0;
    fault_i = 0; fault_slot_i = 0; issue_i = 0; issue_slot_i = 0;
    fault_svc_i = 0; fault_svc_slot_i = 0; cmpl_i = 0; cmpl_slot_i = 0;
    release_i = 0; release_slot_i = 0;
    squash_i = 0; squash_tid_i = 0; squash_seq_i = 0; squash_mem_stall_i = 0;
  endtask

  task automatic cyc();
    @(posedge clk_i); #1; idle();
  endtask

  task automatic alloc(input logic tid, input logic [15:0] seq);
    alloc_req_i = 1; alloc_tid_i = tid; alloc_seq_i = seq;
  endtask

  task automatic squash(input logic tid, input logic [15:0] seq, input logic ms);
    squash_i = 1; squash_tid_i = tid; squash_seq_i = seq; squash_mem_stall_i = ms;
  endtask

  task automatic do_reset();
    idle(); rst_ni = 0; cyc(); cyc(); rst_ni = 1; cyc();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 valid", 32'(slot_valid_o), 0);
    chk("R1 flags", 32'(slot_tlb_stall_o | slot_pending_o | slot_squashed_o), 0);
    chk("R1 blocked", 32'(thread_blocked_o), 0);

    for (int k = 0; k < 5; k++) begin
      alloc(VEC[k].tid, VEC[k].seq);
      #1;
      chk(VEC[k].gnt ? "R2 grant" : "R3 full grant", 32'(alloc_gnt_o), 32'(VEC[k].gnt));
      if (VEC[k].gnt) chk("R2 slot", 32'(alloc_slot_o), 32'(VEC[k].slot));
      cyc();
    end
    chk("R2 valid", 32'(slot_valid_o), 32'hf);
    chk("R2 seq2", 32'(slot_seq_o[47:32]), 30);
    chk("R2 tid", 32'(slot_tid_o), 32'b1010);

    // R5 / R4
    do_reset();
    alloc(0, 100); cyc();
    fault_i = 1; fault_slot_i = 0; cyc();
    chk("R5 stall", 32'(slot_tlb_stall_o), 1);
    chk("R5 blocked", 32'(thread_blocked_o), 1);
    alloc(0, 101); #1;
    chk("R4 refused", 32'(alloc_gnt_o), 0);
    cyc();
    alloc(1, 200); #1;
    chk("R4 other thread", 32'(alloc_gnt_o), 1);
    cyc();

    // R8: squash stalled slot
    squash(0, 99, 0); cyc();
    chk("R8 held", 32'(slot_valid_o[0]), 1);
    chk("R8 squashed", 32'(slot_squashed_o[0]), 1);
    chk("R8 unblocked", 32'(thread_blocked_o), 0);
    fault_svc_i = 1; fault_svc_slot_i = 0; cyc();
    chk("R8 freed", 32'(slot_valid_o), 32'b0010);

    // R6 / R7 / R11
    alloc(1, 210); cyc();
    alloc(1, 190); cyc();
    alloc(0, 205); cyc();
    issue_i = 1; issue_slot_i = 0; cyc();
    chk("R11 pending", 32'(slot_pending_o), 1);
    squash(1, 200, 0); cyc();
    chk("R6 valid", 32'(slot_valid_o), 32'hf);
    chk("R6 squashed", 32'(slot_squashed_o), 32'b0001);
    release_i = 1; release_slot_i = 0; cyc();
    chk("R11 release ignored", 32'(slot_valid_o[0]), 1);
    squash(1, 100, 0); cyc();
    chk("R6 younger freed", 32'(slot_valid_o), 32'b1001);
    chk("R7 skip", 32'(slot_squashed_o), 32'b0001);
    cmpl_i = 1; cmpl_slot_i = 0; #1;
    chk("R7 no deliver", 32'(deliver_o), 0);
    cyc();
    chk("R7 freed", 32'(slot_valid_o), 32'b1000);

    // R9
    alloc(0, 206); cyc();
    squash(0, 205, 1); cyc();
    chk("R9 survives", 32'(slot_valid_o), 32'b1001);
    squash(0, 205, 0); cyc();
    chk("R9 plain squash", 32'(slot_valid_o), 32'b1000);

    // R10: full pool
    alloc(1, 300); cyc();
    alloc(1, 301); cyc();
    alloc(1, 302); cyc();
    chk("R3 full", 32'(slot_valid_o), 32'hf);
    squash(1, 300, 0); alloc(1, 400); #1;
    chk("R10 grant", 32'(alloc_gnt_o), 1);
    chk("R10 slot", 32'(alloc_slot_o), 1);
    cyc();
    chk("R10 valid", 32'(slot_valid_o), 32'b1011);
    chk("R10 not squashed", 32'(slot_squashed_o), 0);
    chk("R10 seq", 32'(slot_seq_o[31:16]), 400);

    // R10 with block
    fault_i = 1; fault_slot_i = 3; cyc();
    chk("R5 blocked t0", 32'(thread_blocked_o), 1);
    squash(0, 100, 0); alloc(0, 500); #1;
    chk("R10 unblock grant", 32'(alloc_gnt_o), 1);
    chk("R10 unblock slot", 32'(alloc_slot_o), 2);
    cyc();
    chk("R8 blocked cleared", 32'(thread_blocked_o), 0);
    chk("R8 squashed held", 32'(slot_squashed_o), 32'b1000);

    // R11 delivery and release
    issue_i = 1; issue_slot_i = 1; cyc();
    cmpl_i = 1; cmpl_slot_i = 1; #1;
    chk("R11 deliver", 32'(deliver_o), 1);
    cyc();
    chk("R11 pending clear", 32'(slot_pending_o), 0);
    chk("R11 still valid", 32'(slot_valid_o[1]), 1);
    release_i = 1; release_slot_i = 1; cyc();
    chk("R11 released", 32'(slot_valid_o), 32'b1101);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule